// File: doc/BRIEF.md
# Time-Slot Interchange Switching Core

This core moves 8-bit channels between parallel input streams and parallel output streams inside a repeating frame. Each frame is 125 µs long and is marked by an 8 kHz frame pulse. The frame is cut into `CHANNELS` slots, one clock cycle per slot. In every slot the byte of each input stream is stored in a data memory, at the location given by that stream and the current slot. At the highest line rate a frame holds 256 slots per stream.

A connection memory has one 16-bit word for each output stream and slot. The word's two top bits pick one of three sources for that output slot:
- an input byte stored in the data memory, at the stream and channel the word names;
- a constant byte that the processor supplied;
- high impedance, flagged by a low enable.

Several outputs may name the same input location, so one input byte can fan out to many outputs.

The processor reaches the connection memory through a read/write port and sets a small control register. Two master enables can silence every output. A block-programming engine can load every connection word with a 2-bit mode pattern and zeros elsewhere, all within one frame.

Top module: `tsi_switch_core`

## Requirements
- R1: A high `frame_i` makes the current cycle slot 0. With no pulse the slot advances by one per cycle and wraps after `CHANNELS-1`. The byte on `in_data_i[s*8+:8]` is stored at data location (stream s, current slot).
- R2: A connection word with mode bits [15:14] equal to 2'b00, or to 2'b10 (handled the same way), switches input data. The source channel is in bits [7:0] and the source stream in bits [13:8]. The output byte for stream s in slot c appears on `out_data_o[s*8+:8]` with `out_en_o[s]` high one cycle after that slot. The byte is the source location's contents as they stood before that slot's own write.
- R3: Mode 2'b01 sends the word's bits [7:0] with the enable high, in every frame until the word is rewritten.
- R4: Mode 2'b11 drives only that output slot to high impedance: the enable is low and the byte is 0.
- R5: When `oe_i` is low and the output-standby control bit 0 is also low, every output has its enable low and its byte 0, whatever the mode bits say. Either signal being high allows outputs.
- R6: A processor write (`cpu_we_i`, address = {stream, channel}, with the channel in the low `log2(CHANNELS)` bits) updates the connection word at that clock edge. The write affects the next output slot that uses the word. `cpu_rdata_o` returns, one cycle later, the word at `cpu_addr_i` as it stood before any write at that edge.
- R7: When control bits 6 (program) and 5 (enable) are both high, the engine writes {pattern, 14'b0} into the words of all streams for channel 0, then channel 1, and so on, one channel per cycle. The pattern is taken from control bits [8:7]. The sweep starts the cycle after the bits are set and finishes in `CHANNELS` cycles, which is one frame.
- R8: At the end of the sweep, control bits [8:5] clear themselves and the other control bits keep their values. `ctrl_o` shows the register.
- R9: When a processor write and a block-programming write hit the same word at the same edge, the block-programming value is stored.
- R10: During reset all output enables are low, all bytes are 0, the control register is 0, and the connection and data memories are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame pulse, marks slot 0 |
| in_data_i | input | STREAMS*8 | Input bytes of the current slot, one per stream |
| oe_i | input | 1 | Master output enable |
| cpu_we_i | input | 1 | Connection-memory write strobe |
| cpu_addr_i | input | ADDR_W | Connection-memory address {stream, channel} |
| cpu_wdata_i | input | 16 | Connection-memory write word |
| cpu_rdata_o | output | 16 | Registered connection-memory read word |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control register write value |
| ctrl_o | output | 16 | Control register contents |
| out_data_o | output | STREAMS*8 | Output bytes, one per stream |
| out_en_o | output | STREAMS | Per-stream output enable (low = high impedance) |

## Verification
The bench targets several corner cases, and each one shows a distinct failure when the design gets it wrong:
- An output reads the same input location in the very slot that location is written. A design without read-before-write would leak the current frame's byte instead of the previous frame's byte.
- A frame pulse arrives early, partway through a frame. A counter that ignores it would put bytes in the wrong slots.
- A processor write collides with the engine on the same word. A design that gave the processor priority would leave the processor value in memory.
- A word is written early but is swept later. Its final value must be the block pattern.
- The outputs are disabled while the standby bit is both clear and set. A design that used AND instead of OR for the two master enables would stay silent with standby set.
- The sweep ends. A missing self-clear would restart the sweep or leave the pattern bits visible in the control register.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    MODE_SW     = 2'b00,
    MODE_CPU    = 2'b01,
    MODE_SW_ALT = 2'b10,
    MODE_HIZ    = 2'b11
  } mode_e;

  localparam int CTRL_STBY   = 0;
  localparam int CTRL_BPE    = 5;
  localparam int CTRL_MBP    = 6;
  localparam int CTRL_PAT_LO = 7;
  localparam int CTRL_PAT_HI = 8;

  localparam int SRC_CH_LSB = 0;
  localparam int SRC_ST_LSB = 8;
endpackage

// File: rtl/tsi_slot_counter.sv
module tsi_slot_counter #(
  parameter int CHANNELS = 8,
  parameter int CH_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  output logic [CH_W-1:0] slot_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(CHANNELS - 1);

  logic [CH_W-1:0] ch_q;

  assign slot_o = frame_i ? '0 : ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= '0;
    else if (slot_o == LAST) ch_q <= '0;
    else ch_q <= slot_o + CH_W'(1);
  end

  // R1
  a_r1_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> ch_q == CH_W'(1 % CHANNELS));
  a_r1_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && ch_q != LAST) |=> ch_q == $past(ch_q) + CH_W'(1));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int STREAMS  = 4,
  parameter int CHANNELS = 8,
  parameter int ST_W     = 2,
  parameter int CH_W     = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [CH_W-1:0]                wr_slot_i,
  input  logic [STREAMS*8-1:0]           in_data_i,
  input  logic [STREAMS-1:0][ST_W-1:0]   rd_st_i,
  input  logic [STREAMS-1:0][CH_W-1:0]   rd_ch_i,
  output logic [STREAMS-1:0][7:0]        rd_data_o
);
  logic [7:0] mem_q [STREAMS][CHANNELS];

  always_comb begin
    for (int s = 0; s < STREAMS; s++) rd_data_o[s] = mem_q[rd_st_i[s]][rd_ch_i[s]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STREAMS; s++)
        for (int c = 0; c < CHANNELS; c++) mem_q[s][c] <= '0;
    end else begin
      for (int s = 0; s < STREAMS; s++) mem_q[s][wr_slot_i] <= in_data_i[s*8 +: 8];
    end
  end

  // R1
  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mem_q[0][$past(wr_slot_i)] == $past(in_data_i[7:0]));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int STREAMS  = 4,
  parameter int CHANNELS = 8,
  parameter int ST_W     = 2,
  parameter int CH_W     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cpu_we_i,
  input  logic [ST_W-1:0]             cpu_st_i,
  input  logic [CH_W-1:0]             cpu_ch_i,
  input  logic [15:0]                 cpu_wdata_i,
  output logic [15:0]                 cpu_rdata_o,
  input  logic                        bp_we_i,
  input  logic [CH_W-1:0]             bp_ch_i,
  input  logic [1:0]                  bp_pat_i,
  input  logic [CH_W-1:0]             slot_i,
  output logic [STREAMS-1:0][15:0]    word_o
);
  logic [15:0] cm_q [STREAMS][CHANNELS];
  logic [15:0] rdata_q;
  logic [15:0] bp_word;

  assign bp_word     = {bp_pat_i, 14'b0};
  assign cpu_rdata_o = rdata_q;

  always_comb begin
    for (int s = 0; s < STREAMS; s++) word_o[s] = cm_q[s][slot_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else rdata_q <= cm_q[cpu_st_i][cpu_ch_i];
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int c = 0; c < CHANNELS; c++) cm_q[s][c] <= '0;
      end else begin
        for (int c = 0; c < CHANNELS; c++) begin
          if (bp_we_i && bp_ch_i == CH_W'(c)) cm_q[s][c] <= bp_word;
          else if (cpu_we_i && cpu_st_i == ST_W'(s) && cpu_ch_i == CH_W'(c))
            cm_q[s][c] <= cpu_wdata_i;
        end
      end
    end
  end

  // R9: engine wins a same-word collision
  a_r9_block_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_we_i && cpu_we_i && cpu_ch_i == bp_ch_i) |=>
      cm_q[$past(cpu_st_i)][$past(cpu_ch_i)] == {$past(bp_pat_i), 14'b0});
  // R7
  a_r7_fill_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_we_i |=> cm_q[0][$past(bp_ch_i)] == {$past(bp_pat_i), 14'b0});
endmodule

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int CHANNELS = 8,
  parameter int CH_W     = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_we_i,
  input  logic [15:0]     ctrl_wdata_i,
  output logic [15:0]     ctrl_o,
  output logic            bp_we_o,
  output logic [CH_W-1:0] bp_ch_o,
  output logic [1:0]      bp_pat_o,
  output logic            stby_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(CHANNELS - 1);

  logic [15:0]     ctrl_q, ctrl_d;
  logic [CH_W-1:0] idx_q;
  logic            active, last, done;

  assign active   = ctrl_q[CTRL_BPE] & ctrl_q[CTRL_MBP];
  assign last     = idx_q == LAST;
  assign done     = active & last;
  assign bp_we_o  = active;
  assign bp_ch_o  = idx_q;
  assign bp_pat_o = ctrl_q[CTRL_PAT_HI:CTRL_PAT_LO];
  assign stby_o   = ctrl_q[CTRL_STBY];
  assign ctrl_o   = ctrl_q;

  always_comb begin
    ctrl_d = ctrl_we_i ? ctrl_wdata_i : ctrl_q;
    if (done) ctrl_d[CTRL_PAT_HI:CTRL_BPE] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      idx_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      idx_q  <= (active && !last) ? idx_q + CH_W'(1) : '0;
    end
  end

  // R7
  a_r7_sweep_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_we_o && bp_ch_o != LAST && !ctrl_we_i) |=>
      bp_we_o && bp_ch_o == $past(bp_ch_o) + CH_W'(1));
  // R8
  a_r8_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_we_o && bp_ch_o == LAST) |=> ctrl_o[CTRL_PAT_HI:CTRL_BPE] == '0 && !bp_we_o);
endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
  import tsi_pkg::*;
#(
  parameter int STREAMS = 4,
  parameter int ST_W    = 2,
  parameter int CH_W    = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         master_en_i,
  input  logic [STREAMS-1:0][15:0]     word_i,
  output logic [STREAMS-1:0][ST_W-1:0] rd_st_o,
  output logic [STREAMS-1:0][CH_W-1:0] rd_ch_o,
  input  logic [STREAMS-1:0][7:0]      rd_data_i,
  output logic [STREAMS*8-1:0]         out_data_o,
  output logic [STREAMS-1:0]           out_en_o
);
  for (genvar s = 0; s < STREAMS; s++) begin : g_st
    mode_e      mode;
    logic       unused_src;
    logic [7:0] data_q;
    logic       en_q;

    assign mode       = mode_e'(word_i[s][15:14]);
    assign rd_st_o[s] = word_i[s][SRC_ST_LSB +: ST_W];
    assign rd_ch_o[s] = word_i[s][SRC_CH_LSB +: CH_W];
    assign unused_src = ^word_i[s][13:0];
    assign out_data_o[s*8 +: 8] = data_q;
    assign out_en_o[s] = en_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        en_q   <= 1'b0;
      end else if (!master_en_i || mode == MODE_HIZ) begin
        data_q <= '0;
        en_q   <= 1'b0;
      end else if (mode == MODE_CPU) begin
        data_q <= word_i[s][7:0];
        en_q   <= 1'b1;
      end else begin
        data_q <= rd_data_i[s];
        en_q   <= 1'b1;
      end
    end

    // R3
    a_r3_const_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (master_en_i && word_i[s][15:14] == 2'b01) |=>
        out_en_o[s] && out_data_o[s*8 +: 8] == $past(word_i[s][7:0]));
    // R4
    a_r4_slot_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_i[s][15:14] == 2'b11) |=> !out_en_o[s] && out_data_o[s*8 +: 8] == 8'h00);
  end
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core #(
  parameter int STREAMS  = 4,
  parameter int CHANNELS = 8,
  localparam int ST_W    = (STREAMS  > 1) ? $clog2(STREAMS)  : 1,
  localparam int CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
  localparam int ADDR_W  = ST_W + CH_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_i,
  input  logic [STREAMS*8-1:0]  in_data_i,
  input  logic                  oe_i,
  input  logic                  cpu_we_i,
  input  logic [ADDR_W-1:0]     cpu_addr_i,
  input  logic [15:0]           cpu_wdata_i,
  output logic [15:0]           cpu_rdata_o,
  input  logic                  ctrl_we_i,
  input  logic [15:0]           ctrl_wdata_i,
  output logic [15:0]           ctrl_o,
  output logic [STREAMS*8-1:0]  out_data_o,
  output logic [STREAMS-1:0]    out_en_o
);
  logic [CH_W-1:0]              slot;
  logic                         bp_we, stby, master_en;
  logic [CH_W-1:0]              bp_ch;
  logic [1:0]                   bp_pat;
  logic [STREAMS-1:0][15:0]     words;
  logic [STREAMS-1:0][ST_W-1:0] rd_st;
  logic [STREAMS-1:0][CH_W-1:0] rd_ch;
  logic [STREAMS-1:0][7:0]      rd_data;

  assign master_en = oe_i | stby;

  tsi_slot_counter #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_slot (
    .clk_i, .rst_ni, .frame_i, .slot_o(slot)
  );

  tsi_ctrl #(.CHANNELS(CHANNELS), .CH_W(CH_W)) u_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .ctrl_o,
    .bp_we_o(bp_we), .bp_ch_o(bp_ch), .bp_pat_o(bp_pat), .stby_o(stby)
  );

  tsi_conn_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .ST_W(ST_W), .CH_W(CH_W)) u_cm (
    .clk_i, .rst_ni, .cpu_we_i,
    .cpu_st_i(cpu_addr_i[ADDR_W-1:CH_W]), .cpu_ch_i(cpu_addr_i[CH_W-1:0]),
    .cpu_wdata_i, .cpu_rdata_o,
    .bp_we_i(bp_we), .bp_ch_i(bp_ch), .bp_pat_i(bp_pat),
    .slot_i(slot), .word_o(words)
  );

  tsi_data_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .ST_W(ST_W), .CH_W(CH_W)) u_dm (
    .clk_i, .rst_ni, .wr_slot_i(slot), .in_data_i,
    .rd_st_i(rd_st), .rd_ch_i(rd_ch), .rd_data_o(rd_data)
  );

  tsi_out_sel #(.STREAMS(STREAMS), .ST_W(ST_W), .CH_W(CH_W)) u_out (
    .clk_i, .rst_ni, .master_en_i(master_en), .word_i(words),
    .rd_st_o(rd_st), .rd_ch_o(rd_ch), .rd_data_i(rd_data),
    .out_data_o, .out_en_o
  );

  // R5
  a_r5_master_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i && !ctrl_o[0]) |=> out_en_o == '0 && out_data_o == '0);
  // R10
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> out_en_o == '0 && ctrl_o == 16'h0000);
endmodule

// File: tb/tsi_switch_core_bench.sv
module tsi_switch_core_bench;
  localparam int ST = 4;
  localparam int CH = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame = 1'b0;
  logic [ST*8-1:0] in_data = '0;
  logic          oe = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0;
  logic [15:0]   cpu_rdata;
  logic          ctrl_we = 1'b0;
  logic [15:0]   ctrl_wdata = '0;
  logic [15:0]   ctrl_q;
  logic [ST*8-1:0] out_data;
  logic [ST-1:0] out_en;

  int total = 0, bad = 0, cyc = 0;
  bit fr_en = 1'b1, finished = 1'b0;

  always #5 clk = ~clk;

  tsi_switch_core #(.STREAMS(ST), .CHANNELS(CH)) u_tsi_switch_core (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .in_data_i(in_data), .oe_i(oe),
    .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_q),
    .out_data_o(out_data), .out_en_o(out_en)
  );

  // reference model
  int          m_ch, m_bp;
  logic [7:0]  m_dm [ST][CH];
  logic [15:0] m_cm [ST][CH];
  logic [15:0] m_ctrl;
  logic [7:0]  e_data [ST];
  logic        e_en [ST];
  string       e_tag [ST];
  logic [15:0] e_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ch = 0; m_bp = 0; m_ctrl = '0; e_rd = '0;
      for (int s = 0; s < ST; s++) begin
        e_data[s] = '0; e_en[s] = 1'b0; e_tag[s] = "R10";
        for (int c = 0; c < CH; c++) begin m_dm[s][c] = '0; m_cm[s][c] = '0; end
      end
    end else begin
      int slot;
      bit master, act, fin;
      logic [15:0] nc;
      slot = frame ? 0 : m_ch;
      master = oe || m_ctrl[0];
      for (int s = 0; s < ST; s++) begin
        logic [15:0] w;
        w = m_cm[s][slot];
        if (!master) begin e_en[s] = 0; e_data[s] = 0; e_tag[s] = "R5"; end
        else if (w[15:14] == 2'b11) begin e_en[s] = 0; e_data[s] = 0; e_tag[s] = "R4"; end
        else if (w[15:14] == 2'b01) begin e_en[s] = 1; e_data[s] = w[7:0]; e_tag[s] = "R3"; end
        else begin
          e_en[s] = 1; e_data[s] = m_dm[w[13:8] % ST][w[7:0] % CH]; e_tag[s] = "R2 R1";
        end
      end
      e_rd = m_cm[cpu_addr / CH][cpu_addr % CH];
      if (cpu_we) m_cm[cpu_addr / CH][cpu_addr % CH] = cpu_wdata;
      act = m_ctrl[5] && m_ctrl[6];
      fin = act && (m_bp == CH - 1);
      if (act) for (int s = 0; s < ST; s++) m_cm[s][m_bp] = {m_ctrl[8:7], 14'b0};
      m_bp = (act && !fin) ? m_bp + 1 : 0;
      for (int s = 0; s < ST; s++) m_dm[s][slot] = in_data[s*8 +: 8];
      nc = ctrl_we ? ctrl_wdata : m_ctrl;
      if (fin) nc[8:5] = 4'b0;
      m_ctrl = nc;
      m_ch = (slot + 1) % CH;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      for (int s = 0; s < ST; s++)
        check(e_tag[s], {23'b0, out_en[s], out_data[s*8 +: 8]}, {23'b0, e_en[s], e_data[s]});
      check("R6 readback", {16'b0, cpu_rdata}, {16'b0, e_rd});
      check("R8 control", {16'b0, ctrl_q}, {16'b0, m_ctrl});
    end
  end

  task automatic tick();
    @(negedge clk);
    cyc++;
    cpu_we = 1'b0;
    ctrl_we = 1'b0;
    frame = fr_en && (cyc % CH == 0);
    for (int s = 0; s < ST; s++) in_data[s*8 +: 8] = 8'(cyc * 7 + s * 29 + 3);
  endtask

  task automatic run(int n);
    repeat (n) tick();
  endtask

  task automatic cpu_wr(int st, int ch, logic [15:0] v);
    tick();
    cpu_we = 1'b1; cpu_addr = AW'(st * CH + ch); cpu_wdata = v;
  endtask

  task automatic ctrl_wr(logic [15:0] v);
    tick();
    ctrl_we = 1'b1; ctrl_wdata = v;
  endtask

  task automatic read_check(string tag, int st, int ch, logic [15:0] exp);
    tick();
    cpu_addr = AW'(st * CH + ch);
    tick();
    check(tag, {16'b0, cpu_rdata}, {16'b0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 enables", {28'b0, out_en}, 32'h0);
    check("R10 data", out_data, 32'h0);
    check("R10 control", {16'b0, ctrl_q}, 32'h0);
    rst_n = 1'b1;
    oe = 1'b1;
    run(10);
    // switched, fan-out, constant, tristate, alias mode, same-slot source
    cpu_wr(0, 0, {2'b00, 6'd2, 8'd5});
    cpu_wr(1, 0, {2'b00, 6'd2, 8'd5});
    cpu_wr(0, 1, {2'b01, 6'd0, 8'hA5});
    cpu_wr(2, 3, {2'b11, 6'd1, 8'd2});
    cpu_wr(3, 4, {2'b10, 6'd1, 8'd7});
    cpu_wr(1, 6, {2'b00, 6'd3, 8'd6});
    cpu_wr(2, 2, {2'b00, 6'd0, 8'd2});
    run(40);
    read_check("R6 word read", 0, 1, {2'b01, 6'd0, 8'hA5});
    // R3: constant follows a rewrite
    cpu_wr(0, 1, {2'b01, 6'd0, 8'h3C});
    run(20);
    // R5: both enables low, then standby high
    oe = 1'b0;
    run(16);
    ctrl_wr(16'h0001);
    run(16);
    ctrl_wr(16'h0000);
    run(4);
    oe = 1'b1;
    // R7, R9: block program pattern 01 with collision
    cpu_wr(2, 7, 16'h0077);
    ctrl_wr(16'h00E1);
    cpu_wr(1, 0, 16'h1234);
    run(12);
    check("R8 self clear", {16'b0, ctrl_q}, 32'h0001);
    read_check("R9 collision", 1, 0, 16'h4000);
    read_check("R7 late channel", 2, 7, 16'h4000);
    run(10);
    // pattern 11: every slot tristate
    ctrl_wr(16'h01E1);
    run(12);
    check("R4 all hiz", {28'b0, out_en}, 32'h0);
    // pattern 00 then remap
    ctrl_wr(16'h0061);
    run(12);
    read_check("R7 zero fill", 3, 5, 16'h0000);
    cpu_wr(0, 2, {2'b00, 6'd3, 8'd1});
    cpu_wr(3, 5, {2'b00, 6'd0, 8'd5});
    run(20);
    // R1: early frame pulses
    fr_en = 1'b0;
    run(3);
    tick(); frame = 1'b1;
    run(5);
    tick(); frame = 1'b1;
    run(13);
    tick(); frame = 1'b1;
    run(20);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R1: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule